// File: doc/BRIEF.md
# Handshake-terminated 16-bit bus master

This block lets a core that works on 32-bit operands reach memory and peripherals over a 16-bit external bus. The core pulses a request carrying a byte address, a transfer size (byte, word or long), a direction flag and write data. The block then runs one or two bus cycles. Each cycle drives a word address and a direction line, an address strobe, and an upper and a lower byte strobe. The cycle stays open until the slave answers with an active-low acknowledge.

The acknowledge arrives asynchronously, so it passes through a synchronizer before the sequencer acts on it. A slave may therefore hold a cycle open for any number of clocks. A long operand is carried as two word cycles, high half first. Word and long requests at odd addresses are refused with an error pulse and never reach the bus.

A request is taken only while the block is idle. The core issues it as a one-clock pulse and then waits for either `rsp_done` or `rsp_err`.

Top module: `strobe_bus_master`

## Requirements
- R1: While reset is held and after it is released, the address strobe and both byte strobes are high (inactive), `bus_rw` is 1, `bus_dout_en` is 0, and neither `rsp_done` nor `rsp_err` is set.
- R2: The bus address carries byte-address bits 23..1 of the request, so `bus_addr` bit 0 is address bit 1. Bits 31..24 are dropped. `bus_rw` is 1 for a read and 0 for a write. Address and direction stay unchanged while the address strobe is asserted.
- R3: The address strobe is low only while a valid address and direction are on the bus. Either byte strobe is low only while the address strobe is low.
- R4: `req_size` is encoded as 0 for byte, 1 for word, and 2 or 3 for long. A byte at an even address asserts only `bus_uds_n`, which is the D15..D8 lane. A byte at an odd address asserts only `bus_lds_n`, which is the D7..D0 lane. Word and long cycles assert both strobes.
- R5: A byte write drives `req_wdata[7:0]` on both lanes of `bus_dout`. A word write drives `req_wdata[15:0]`. `bus_dout_en` is 1 only during write cycles.
- R6: A bus cycle stays open, with all its strobes asserted, until the synchronized acknowledge is seen, however many clocks that takes. `rsp_done` pulses for one clock when the transfer completes.
- R7: A long transfer runs two cycles. The first moves `req_wdata[31:16]` or read bits 31..16 at the given address. The second moves the low half at the address plus 2. `rsp_done` pulses only after the second acknowledge.
- R8: All strobes go high on the clock after the acknowledge is seen and stay high for at least one clock. The next cycle of a long transfer begins only after the acknowledge has been released.
- R9: A word or long request with address bit 0 set gives a one-clock `rsp_err` pulse, starts no bus cycle and gives no `rsp_done`.
- R10: `rsp_rdata` is valid while `rsp_done` is high. A byte read returns the addressed lane, zero-extended in bits 7..0. A word read returns the bus word, zero-extended. A long read returns the first word in bits 31..16 and the second word in bits 15..0.
- R11: A request pulse that arrives while a transfer is in progress is ignored and starts no further bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-clock request pulse, taken only when idle |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write operand, right-aligned |
| rsp_done | output | 1 | One-clock pulse when the transfer completes |
| rsp_err | output | 1 | One-clock pulse for a misaligned request |
| rsp_rdata | output | 32 | Read operand, valid with `rsp_done` |
| bus_addr | output | 23 | Word address, address bits 23..1 |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper byte strobe (D15..D8), active low |
| bus_lds_n | output | 1 | Lower byte strobe (D7..D0), active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_dout | output | 16 | Write data toward the bus |
| bus_dout_en | output | 1 | Enable for the write-data drivers |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Asynchronous transfer acknowledge, active low |

## Verification
The hardest case to reach from the ports is the gap between the two halves of a long transfer. That case needs a slave that keeps its acknowledge asserted for several clocks after the strobes have gone high, so that the sequencer has to wait in its recovery state. The bench slave model holds the acknowledge for a chosen number of clocks after it sees the strobes go high, and checks that the address strobe stays high for that whole time. It also inserts a chosen number of wait states before acknowledging, so that stalls of different lengths can be checked. A second request pulse is injected in the middle of a stalled cycle, and the bench then confirms that only one bus cycle follows.

// File: rtl/sbm_pkg.sv
// Package: shared encodings for the handshake bus master.
// Assumes: transfer size uses two bits; values 2 and 3 both mean long.
package sbm_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sbm_ack_sync.sv
// Module: brings the asynchronous active-low acknowledge into the clock domain.
// Assumes: STAGES >= 1; the output is active high and resets to "not seen".
module sbm_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_async,
    output logic ack_seen
);

    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= ack_n_async;
            end
        end else begin : g_chain
            // Shift chain of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], ack_n_async};
            end
        end
    endgenerate

    assign ack_seen = ~sync_q[STAGES-1];

endmodule

// File: rtl/sbm_lane_map.sv
// Module: decides strobes and write-lane data for the cycle about to start.
// Assumes: the bus has two byte lanes; the upper lane serves even addresses.
module sbm_lane_map #(
    parameter int BUS_DW = 16,
    localparam int LANE_W = BUS_DW / 2,
    localparam int CORE_DW = 2 * BUS_DW
) (
    input  logic [1:0]         size,
    input  logic               addr_lsb,
    input  logic               second_half,
    input  logic [CORE_DW-1:0] wdata,
    output logic               uds_act,
    output logic               lds_act,
    output logic [BUS_DW-1:0]  lane_wdata
);

    import sbm_pkg::*;

    // Strobe and lane selection from size, address bit 0 and cycle half.
    always_comb begin
        uds_act    = 1'b1;
        lds_act    = 1'b1;
        lane_wdata = wdata[BUS_DW-1:0];
        if (size == SZ_BYTE) begin
            uds_act    = ~addr_lsb;
            lds_act    = addr_lsb;
            lane_wdata = {2{wdata[LANE_W-1:0]}};
        end else if (size[1]) begin
            lane_wdata = second_half ? wdata[BUS_DW-1:0] : wdata[CORE_DW-1:BUS_DW];
        end
    end

endmodule

// File: rtl/sbm_read_merge.sv
// Module: folds the word on the bus into the operand being assembled.
// Assumes: byte reads are right-aligned and zero-extended; longs arrive high half first.
module sbm_read_merge #(
    parameter int BUS_DW = 16,
    localparam int LANE_W = BUS_DW / 2,
    localparam int CORE_DW = 2 * BUS_DW
) (
    input  logic [1:0]         size,
    input  logic               addr_lsb,
    input  logic               second_half,
    input  logic [BUS_DW-1:0]  din,
    input  logic [CORE_DW-1:0] held,
    output logic [CORE_DW-1:0] merged
);

    import sbm_pkg::*;

    // Operand assembly for the cycle now being acknowledged.
    always_comb begin
        merged = '0;
        if (size == SZ_BYTE) begin
            merged[LANE_W-1:0] = addr_lsb ? din[LANE_W-1:0] : din[BUS_DW-1:LANE_W];
        end else if (size == SZ_WORD) begin
            merged[BUS_DW-1:0] = din;
        end else if (second_half) begin
            merged = {held[CORE_DW-1:BUS_DW], din};
        end else begin
            merged = {din, held[BUS_DW-1:0]};
        end
    end

endmodule

// File: rtl/sbm_seq.sv
// Module: cycle sequencer; owns all registered bus and response outputs.
// Assumes: request is a pulse taken only in idle; ack_det is already synchronized.
module sbm_seq #(
    parameter int CORE_AW = 32,
    parameter int BUS_AW  = 24,
    parameter int BUS_DW  = 16,
    localparam int CORE_DW = 2 * BUS_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [CORE_AW-1:0] req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [CORE_DW-1:0] req_wdata,
    input  logic               ack_det,
    input  logic               uds_act,
    input  logic               lds_act,
    input  logic [BUS_DW-1:0]  lane_wdata,
    input  logic [CORE_DW-1:0] merged,
    output logic [1:0]         sel_size,
    output logic               sel_lsb,
    output logic               sel_half,
    output logic [CORE_DW-1:0] sel_wdata,
    output logic [CORE_DW-1:0] held,
    output logic [BUS_AW-2:0]  bus_addr,
    output logic               bus_as_n,
    output logic               bus_uds_n,
    output logic               bus_lds_n,
    output logic               bus_rw,
    output logic [BUS_DW-1:0]  bus_dout,
    output logic               bus_dout_en,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic [CORE_DW-1:0] rsp_rdata
);

    import sbm_pkg::*;

    seq_state_e         state_q;
    logic [1:0]         size_q;
    logic               lsb_q;
    logic               write_q;
    logic               phase_q;
    logic [CORE_DW-1:0] wdata_q;
    logic [CORE_DW-1:0] held_q;
    logic               idle;
    logic               misaligned;
    logic               unused_hi_addr;

    // Address bits above the bus width are dropped on purpose.
    assign unused_hi_addr = ^req_addr[CORE_AW-1:BUS_AW];

    // Selection fields for the lane map and the read merge.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        sel_size   = idle ? req_size  : size_q;
        sel_lsb    = idle ? req_addr[0] : lsb_q;
        sel_wdata  = idle ? req_wdata : wdata_q;
        sel_half   = (state_q == ST_RECOVER) | phase_q;
        misaligned = (req_size != SZ_BYTE) && req_addr[0];
    end

    assign held = held_q;

    // Cycle sequencing: start, wait for acknowledge, recover, repeat or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            size_q      <= SZ_BYTE;
            lsb_q       <= 1'b0;
            write_q     <= 1'b0;
            phase_q     <= 1'b0;
            wdata_q     <= '0;
            held_q      <= '0;
            bus_addr    <= '0;
            bus_as_n    <= 1'b1;
            bus_uds_n   <= 1'b1;
            bus_lds_n   <= 1'b1;
            bus_rw      <= 1'b1;
            bus_dout    <= '0;
            bus_dout_en <= 1'b0;
            rsp_done    <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (misaligned) begin
                            rsp_err <= 1'b1;
                        end else begin
                            size_q      <= req_size;
                            lsb_q       <= req_addr[0];
                            write_q     <= req_write;
                            wdata_q     <= req_wdata;
                            phase_q     <= 1'b0;
                            held_q      <= '0;
                            bus_addr    <= req_addr[BUS_AW-1:1];
                            bus_rw      <= ~req_write;
                            bus_as_n    <= 1'b0;
                            bus_uds_n   <= ~uds_act;
                            bus_lds_n   <= ~lds_act;
                            bus_dout    <= lane_wdata;
                            bus_dout_en <= req_write;
                            state_q     <= ST_ACTIVE;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (ack_det) begin
                        held_q      <= merged;
                        bus_as_n    <= 1'b1;
                        bus_uds_n   <= 1'b1;
                        bus_lds_n   <= 1'b1;
                        bus_dout_en <= 1'b0;
                        state_q     <= ST_RECOVER;
                    end
                end
                ST_RECOVER: begin
                    if (!ack_det) begin
                        if (size_q[1] && !phase_q) begin
                            phase_q     <= 1'b1;
                            bus_addr    <= bus_addr + 1'b1;
                            bus_as_n    <= 1'b0;
                            bus_uds_n   <= ~uds_act;
                            bus_lds_n   <= ~lds_act;
                            bus_dout    <= lane_wdata;
                            bus_dout_en <= write_q;
                            state_q     <= ST_ACTIVE;
                        end else begin
                            rsp_rdata <= held_q;
                            rsp_done  <= 1'b1;
                            phase_q   <= 1'b0;
                            state_q   <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/strobe_bus_master.sv
// Module: top of the handshake-terminated 16-bit bus master.
// Assumes: one outstanding request; slave keeps read data valid while acknowledging.
module strobe_bus_master #(
    parameter int CORE_AW     = 32,
    parameter int BUS_AW      = 24,
    parameter int BUS_DW      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CORE_DW = 2 * BUS_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [CORE_AW-1:0] req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [CORE_DW-1:0] req_wdata,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic [CORE_DW-1:0] rsp_rdata,
    output logic [BUS_AW-2:0]  bus_addr,
    output logic               bus_as_n,
    output logic               bus_uds_n,
    output logic               bus_lds_n,
    output logic               bus_rw,
    output logic [BUS_DW-1:0]  bus_dout,
    output logic               bus_dout_en,
    input  logic [BUS_DW-1:0]  bus_din,
    input  logic               bus_ack_n
);

    logic               ack_det;
    logic [1:0]         sel_size;
    logic               sel_lsb;
    logic               sel_half;
    logic [CORE_DW-1:0] sel_wdata;
    logic [CORE_DW-1:0] held;
    logic               uds_act;
    logic               lds_act;
    logic [BUS_DW-1:0]  lane_wdata;
    logic [CORE_DW-1:0] merged;

    sbm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_async (bus_ack_n),
        .ack_seen    (ack_det)
    );

    sbm_lane_map #(.BUS_DW(BUS_DW)) u_lane (
        .size        (sel_size),
        .addr_lsb    (sel_lsb),
        .second_half (sel_half),
        .wdata       (sel_wdata),
        .uds_act     (uds_act),
        .lds_act     (lds_act),
        .lane_wdata  (lane_wdata)
    );

    sbm_read_merge #(.BUS_DW(BUS_DW)) u_merge (
        .size        (sel_size),
        .addr_lsb    (sel_lsb),
        .second_half (sel_half),
        .din         (bus_din),
        .held        (held),
        .merged      (merged)
    );

    sbm_seq #(.CORE_AW(CORE_AW), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .ack_det     (ack_det),
        .uds_act     (uds_act),
        .lds_act     (lds_act),
        .lane_wdata  (lane_wdata),
        .merged      (merged),
        .sel_size    (sel_size),
        .sel_lsb     (sel_lsb),
        .sel_half    (sel_half),
        .sel_wdata   (sel_wdata),
        .held        (held),
        .bus_addr    (bus_addr),
        .bus_as_n    (bus_as_n),
        .bus_uds_n   (bus_uds_n),
        .bus_lds_n   (bus_lds_n),
        .bus_rw      (bus_rw),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .rsp_done    (rsp_done),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/sbm_checker.sv
// Module: protocol checks for the bus master, attached by bind.
// Assumes: ack_det is the synchronized acknowledge inside the top.
module sbm_checker #(
    parameter int AW = 23
) (
    input logic          clk,
    input logic          rst_n,
    input logic          as_n,
    input logic          uds_n,
    input logic          lds_n,
    input logic          rw,
    input logic [AW-1:0] addr,
    input logic          ack_det,
    input logic          done,
    input logic          err
);

    AST_STROBE_IN_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (!uds_n || !lds_n) |-> !as_n); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && $past(!as_n)) |-> ($stable(addr) && $stable(rw))); // R2

    AST_WAIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !ack_det) |=> !as_n); // R6

    AST_NEGATE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && ack_det) |=> as_n); // R8

    AST_START_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> !$past(ack_det)); // R8

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> as_n); // R9

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R9

endmodule

bind strobe_bus_master sbm_checker #(.AW(BUS_AW - 1)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (bus_as_n),
    .uds_n   (bus_uds_n),
    .lds_n   (bus_lds_n),
    .rw      (bus_rw),
    .addr    (bus_addr),
    .ack_det (ack_det),
    .done    (rsp_done),
    .err     (rsp_err)
);

// File: tb/strobe_bus_master_tb.sv
// Bench: directed scenarios with a slave model of adjustable wait and hold.
module strobe_bus_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [22:0] bus_addr;
    logic        bus_as_n;
    logic        bus_uds_n;
    logic        bus_lds_n;
    logic        bus_rw;
    logic [15:0] bus_dout;
    logic        bus_dout_en;
    logic [15:0] bus_din = '0;
    logic        bus_ack_n = 1'b1;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int as_starts = 0;
    logic as_prev = 1'b1;

    always #5 clk = ~clk;

    strobe_bus_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
        .bus_lds_n(bus_lds_n), .bus_rw(bus_rw), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
    );

    // Event counters sampled between edges.
    always @(negedge clk) begin
        if (rsp_done) done_cnt++;
        if (rsp_err) err_cnt++;
        if (!bus_as_n && as_prev) as_starts++;
        as_prev = bus_as_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic [31:0] wd);
        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(output logic [31:0] rd);
        while (!(rsp_done || rsp_err)) @(negedge clk);
        rd = rsp_rdata;
        @(negedge clk);
    endtask

    // Slave: answers one cycle after `waits` stall clocks, holds ack `hold` clocks after strobes drop.
    task automatic slave_cycle(input int waits, input int hold, input logic [15:0] rd,
                               output logic [22:0] a, output logic u, output logic l,
                               output logic rw, output logic [15:0] d);
        logic stalled;
        logic early;
        stalled = 1'b0;
        early = 1'b0;
        @(negedge clk);
        while (bus_as_n) @(negedge clk);
        a = bus_addr; u = bus_uds_n; l = bus_lds_n; rw = bus_rw; d = bus_dout;
        chk("R5 dout_en follows direction", {31'd0, bus_dout_en}, {31'd0, ~bus_rw});
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            if (bus_as_n || (bus_uds_n && bus_lds_n)) stalled = 1'b1;
        end
        chk("R6 cycle held during wait states", {31'd0, stalled}, 32'd0);
        bus_din = rd;
        bus_ack_n = 1'b0;
        @(negedge clk);
        while (!bus_as_n) @(negedge clk);
        chk("R3 strobes off with address strobe", {30'd0, bus_uds_n, bus_lds_n}, 32'd3);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!bus_as_n) early = 1'b1;
        end
        chk("R8 no new cycle before ack release", {31'd0, early}, 32'd0);
        bus_ack_n = 1'b1;
        bus_din = '0;
    endtask

    task automatic t_reset();
        chk("R1 idle outputs after reset",
            {26'd0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, rsp_done, rsp_err}, 32'h3C);
        chk("R1 dout_en low after reset", {31'd0, bus_dout_en}, 32'd0);
    endtask

    task automatic t_byte_read(input logic [31:0] a, input logic [15:0] bw, input logic [7:0] exp);
        logic [22:0] sa; logic su, sl, srw; logic [15:0] sd; logic [31:0] r;
        fork
            slave_cycle(3, 1, bw, sa, su, sl, srw, sd);
            begin issue(a, 2'd0, 1'b0, 32'd0); wait_end(r); end
        join
        chk("R2 byte read word address", {9'd0, sa}, {9'd0, a[23:1]});
        chk("R2 read direction", {31'd0, srw}, 32'd1);
        chk("R4 byte read strobes", {30'd0, su, sl}, {30'd0, a[0], ~a[0]});
        chk("R10 byte read data", r, {24'd0, exp});
    endtask

    task automatic t_byte_write();
        logic [22:0] sa; logic su, sl, srw; logic [15:0] sd; logic [31:0] r; int d0;
        d0 = done_cnt;
        fork
            slave_cycle(0, 0, 16'd0, sa, su, sl, srw, sd);
            begin issue(32'h0000_0101, 2'd0, 1'b1, 32'h1122_337E); wait_end(r); end
        join
        chk("R5 byte write replicated", {16'd0, sd}, 32'h0000_7E7E);
        chk("R2 write direction", {31'd0, srw}, 32'd0);
        chk("R4 odd byte write lower strobe only", {30'd0, su, sl}, 32'd2);
        chk("R6 one done pulse", done_cnt - d0, 32'd1);
    endtask

    task automatic t_word_write();
        logic [22:0] sa; logic su, sl, srw; logic [15:0] sd; logic [31:0] r;
        fork
            slave_cycle(7, 2, 16'd0, sa, su, sl, srw, sd);
            begin issue(32'h55FF_FFFE, 2'd1, 1'b1, 32'hDEAD_BEEF); wait_end(r); end
        join
        chk("R5 word write data", {16'd0, sd}, 32'h0000_BEEF);
        chk("R2 top address dropped", {9'd0, sa}, 32'h007F_FFFF);
        chk("R4 word both strobes", {30'd0, su, sl}, 32'd0);
    endtask

    task automatic t_long_read();
        logic [22:0] a1, a2; logic su, sl, srw; logic [15:0] sd; logic [31:0] r;
        int d0, s0, dmid;
        d0 = done_cnt; s0 = as_starts; dmid = 0;
        fork
            begin
                slave_cycle(2, 3, 16'h1234, a1, su, sl, srw, sd);
                dmid = done_cnt - d0;
                slave_cycle(0, 2, 16'h5678, a2, su, sl, srw, sd);
            end
            begin issue(32'h0000_1000, 2'd2, 1'b0, 32'd0); wait_end(r); end
        join
        chk("R7 first half address", {9'd0, a1}, 32'h0000_0800);
        chk("R7 second half address", {9'd0, a2}, 32'h0000_0801);
        chk("R7 no done after first ack", dmid, 32'd0);
        chk("R7 two bus cycles", as_starts - s0, 32'd2);
        chk("R10 long read assembly", r, 32'h1234_5678);
    endtask

    task automatic t_long_write();
        logic [22:0] a1, a2; logic su, sl, srw; logic [15:0] d1, d2; logic [31:0] r;
        fork
            begin
                slave_cycle(1, 0, 16'd0, a1, su, sl, srw, d1);
                slave_cycle(4, 1, 16'd0, a2, su, sl, srw, d2);
            end
            begin issue(32'h0020_0004, 2'd3, 1'b1, 32'hCAFE_F00D); wait_end(r); end
        join
        chk("R7 long write high half first", {16'd0, d1}, 32'h0000_CAFE);
        chk("R7 long write low half second", {16'd0, d2}, 32'h0000_F00D);
        chk("R7 long write second address", {9'd0, a2}, 32'h0010_0003);
    endtask

    task automatic t_misaligned(input logic [1:0] sz, input logic [31:0] a);
        logic [31:0] r; int e0, s0, d0;
        e0 = err_cnt; s0 = as_starts; d0 = done_cnt;
        issue(a, sz, 1'b0, 32'd0);
        wait_end(r);
        repeat (4) @(negedge clk);
        chk("R9 error pulse", err_cnt - e0, 32'd1);
        chk("R9 no bus cycle", as_starts - s0, 32'd0);
        chk("R9 no done", done_cnt - d0, 32'd0);
    endtask

    task automatic t_busy_ignore();
        logic [22:0] sa; logic su, sl, srw; logic [15:0] sd; logic [31:0] r; int s0;
        s0 = as_starts;
        fork
            slave_cycle(10, 1, 16'h4242, sa, su, sl, srw, sd);
            begin
                issue(32'h0000_0200, 2'd1, 1'b0, 32'd0);
                repeat (3) @(negedge clk);
                issue(32'h0000_0400, 2'd1, 1'b1, 32'h0000_9999);
                wait_end(r);
                repeat (10) @(negedge clk);
            end
        join
        chk("R11 request while busy ignored", as_starts - s0, 32'd1);
        chk("R10 word read zero extended", r, 32'h0000_4242);
        chk("R11 address of first request kept", {9'd0, sa}, 32'h0000_0100);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_byte_read(32'hAB12_3456, 16'hA53C, 8'hA5);
        t_byte_read(32'h0001_2345, 16'hA53C, 8'h3C);
        t_byte_write();
        t_word_write();
        t_long_read();
        t_long_write();
        t_misaligned(2'd1, 32'h0000_0103);
        t_misaligned(2'd2, 32'h0000_0105);
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule